// File: doc/BRIEF.md
# Field-Event Interrupt Controller

This unit sits beside a video timing generator and turns its per-field start pulses into a single level-sensitive interrupt line. There are two sources, one for the start of a bottom field and one for the start of a top field. Each pulse sets a sticky status bit. A per-source enable mask decides which of those bits may raise the interrupt. The mask never stops a bit from being recorded.

Software never performs read-modify-write on this unit. Status bits are cleared by writing ones to a dedicated clear address. Mask bits are changed through two addresses, one that sets and one that clears, where each written 1 acts on its bit and each 0 leaves its bit alone. Host access is a simple one-cycle write strobe and a one-cycle read strobe. Read data returns one cycle after the read strobe, and a matching valid flag comes with it.

Top module: `fevt_irq_ctrl`

## Requirements
- R1: After reset, status and mask read back as zero and `irq` is low.
- R2: A pulse on `evt_bot` sets status bit 0 and a pulse on `evt_top` sets status bit 1, at the next clock edge, whatever the mask holds.
- R3: A write to address 1 (status clear) clears exactly the status bits whose data bit is 1, and leaves all other status bits unchanged.
- R4: A write to address 3 (mask set) sets the mask bits written as 1, and a write to address 2 (mask clear) clears the mask bits written as 1. Mask bits written as 0 keep their value.
- R5: `irq` is high exactly when some status bit and the same mask bit are both set, and it follows the registered state in the same cycle.
- R6: When an event pulse and a status-clear write hit the same bit in the same cycle, the event wins and the bit is set afterwards.
- R7: A read strobe at address 0 returns status and at address 4 returns mask, on `rd_data` with `rd_vld` high one cycle later. Unimplemented bits (15:2) read 0, and any other address reads 0.
- R8: Status and mask are 16-bit fields. Writing 0xFFFF to the status-clear or mask-clear address clears every bit of that field.
- R9: Writes to the read addresses 0 and 4 have no effect on status or mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bot | input | 1 | Bottom-field start pulse |
| evt_top | input | 1 | Top-field start pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, one cycle after the strobe |
| rd_vld | output | 1 | Marks `rd_data` as valid |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
A field-start pulse and a host clear of the same status bit can land in the same cycle. This is the collision that decides whether an interrupt is lost. The bench drives the pulse and the status-clear write within a single step, first on the same bit and then on opposite bits. It then reads status back and samples `irq`, expecting the pulsed bit to be held and the other bit to be gone. Mask set and clear writes that coincide with pending status bits are judged the same way, through the level of `irq` right after the edge.

// File: rtl/fevt_pkg.sv
package fevt_pkg;
   // host address map (word addresses)
   localparam int ADR_STAT_RD  = 0;
   localparam int ADR_STAT_CLR = 1;
   localparam int ADR_MASK_CLR = 2;
   localparam int ADR_MASK_SET = 3;
   localparam int ADR_MASK_RD  = 4;
   // source bit positions
   localparam int SRC_BOT   = 0;
   localparam int SRC_TOP   = 1;
   localparam int NUM_SRC   = 2;
endpackage

// File: rtl/fevt_status_reg.sv
module fevt_status_reg #(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_vec,
   output logic [REG_W-1:0] status
);
   genvar i;
   generate
      for (i = 0; i < REG_W; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (set_vec[i])
               bit_q <= 1'b1;              // a new event beats a clear
            else if (clr_en && clr_vec[i])
               bit_q <= 1'b0;
         end
         assign status[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/fevt_mask_reg.sv
module fevt_mask_reg #(
   parameter int MW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic          clr_en,
   input  logic [MW-1:0] data,
   output logic [MW-1:0] mask
);
   genvar i;
   generate
      for (i = 0; i < MW; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (set_en && data[i])
               bit_q <= 1'b1;
            else if (clr_en && data[i])
               bit_q <= 1'b0;
         end
         assign mask[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/fevt_rd_mux.sv
module fevt_rd_mux #(
   parameter int REG_W  = 16,
   parameter int MW     = 2,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [REG_W-1:0]  status,
   input  logic [MW-1:0]     mask,
   output logic [REG_W-1:0]  rd_data,
   output logic              rd_vld
);
   import fevt_pkg::*;
   logic [REG_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (rd_addr == ADDR_W'(ADR_STAT_RD))
         sel = status;
      else if (rd_addr == ADDR_W'(ADR_MASK_RD))
         sel = REG_W'(mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_en;
         if (rd_en)
            rd_data <= sel;
      end
   end
endmodule

// File: rtl/fevt_irq_ctrl.sv
module fevt_irq_ctrl #(
   parameter int REG_W   = 16,
   parameter int ADDR_W  = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_bot,
   input  logic              evt_top,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              rd_vld,
   output logic              irq
);
   import fevt_pkg::*;
   localparam int MW = NUM_SRC;

   generate
      if (REG_W < MW || REG_W > 32) begin : g_bad_width
         $error("fevt_irq_ctrl: REG_W out of range");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("fevt_irq_ctrl: ADDR_W too small for address map");
      end
   endgenerate

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] status_q;
   logic [MW-1:0]    mask_q;
   logic             stat_clr, msk_set, msk_clr;
   logic             irq_raw;

   always_comb begin
      set_vec          = '0;
      set_vec[SRC_BOT] = evt_bot;
      set_vec[SRC_TOP] = evt_top;
   end

   assign stat_clr = wr_en && (wr_addr == ADDR_W'(ADR_STAT_CLR));
   assign msk_clr  = wr_en && (wr_addr == ADDR_W'(ADR_MASK_CLR));
   assign msk_set  = wr_en && (wr_addr == ADDR_W'(ADR_MASK_SET));

   fevt_status_reg #(.REG_W(REG_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_en  (stat_clr),
      .clr_vec (wr_data),
      .status  (status_q)
   );

   fevt_mask_reg #(.MW(MW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (msk_set),
      .clr_en (msk_clr),
      .data   (wr_data[MW-1:0]),
      .mask   (mask_q)
   );

   fevt_rd_mux #(.REG_W(REG_W), .MW(MW), .ADDR_W(ADDR_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .status  (status_q),
      .mask    (mask_q),
      .rd_data (rd_data),
      .rd_vld  (rd_vld)
   );

   assign irq_raw = |(status_q[MW-1:0] & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/fevt_irq_chk.sv
module fevt_irq_chk #(
   parameter int REG_W  = 16,
   parameter int ADDR_W = 3,
   parameter int MW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_bot,
   input logic              evt_top,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  status_q,
   input logic [MW-1:0]     mask_q,
   input logic              irq
);
   import fevt_pkg::*;

   // R2: bottom pulse always lands in status bit 0
   assert_bot_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_bot |=> status_q[SRC_BOT]);

   // R6: top pulse survives a same-cycle clear of bit 1
   assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_top && wr_en && wr_addr == ADDR_W'(ADR_STAT_CLR) && wr_data[SRC_TOP])
      |=> status_q[SRC_TOP]);

   // R3: a clear with no competing pulse drops the bit
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADR_STAT_CLR) && wr_data[SRC_BOT] && !evt_bot)
      |=> !status_q[SRC_BOT]);

   // R4: mask set raises the bit, mask clear lowers it
   assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADR_MASK_SET) && wr_data[SRC_TOP])
      |=> mask_q[SRC_TOP]);
   assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADR_MASK_CLR) && wr_data[SRC_BOT])
      |=> !mask_q[SRC_BOT]);

   // R5: with the mask empty now and one cycle ago, the line stays low
   assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && $past(mask_q) == '0) |-> !irq);

   // R9: a write to a read address leaves the mask untouched
   assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(ADR_STAT_RD) || wr_addr == ADDR_W'(ADR_MASK_RD)))
      |=> $stable(mask_q));
endmodule

bind fevt_irq_ctrl fevt_irq_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MW(fevt_pkg::NUM_SRC)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_bot  (evt_bot),
   .evt_top  (evt_top),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .status_q (status_q),
   .mask_q   (mask_q),
   .irq      (irq)
);

// File: tb/fevt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fevt_irq_ctrl_tb_top;
   localparam int W  = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_bot = 1'b0, evt_top = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic          rd_vld, irq;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   fevt_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_bot(evt_bot), .evt_top(evt_top),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_vld(rd_vld), .irq(irq)
   );

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && rd_vld) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read: got %h expected none", rd_data);
         end else begin
            logic [W-1:0] e;
            string        t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: rd_data got %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   // one clocked step; called and returns at a falling edge
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                       input logic eb, input logic et);
      wr_en = we; wr_addr = wa; wr_data = wd; evt_bot = eb; evt_top = et;
      @(negedge clk);
      wr_en = 1'b0; evt_bot = 1'b0; evt_top = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      step(1'b1, a, d, 1'b0, 1'b0);
   endtask

   // driver: issue a read and push its expected value
   task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq got %b expected %b", t, irq, e);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk_irq(1'b0, "R1 reset irq");
      rd(3'd0, 16'h0000, "R1 reset status");
      rd(3'd4, 16'h0000, "R1 reset mask");
      // R2: events latch with mask empty
      step(1'b0, 3'd0, '0, 1'b1, 1'b0);
      chk_irq(1'b0, "R2 masked bottom");
      rd(3'd0, 16'h0001, "R2 bottom sets bit0");
      step(1'b0, 3'd0, '0, 1'b0, 1'b1);
      rd(3'd0, 16'h0003, "R2 top sets bit1");
      // R4 / R5: enable top
      wr(3'd3, 16'h0002);
      chk_irq(1'b1, "R5 top pending and enabled");
      rd(3'd4, 16'h0002, "R4 mask set bit1");
      // R3: clear top only
      wr(3'd1, 16'h0002);
      chk_irq(1'b0, "R5 top cleared");
      rd(3'd0, 16'h0001, "R3 clear leaves bit0");
      wr(3'd3, 16'h0001);
      chk_irq(1'b1, "R5 bottom enabled");
      rd(3'd4, 16'h0003, "R4 mask set keeps bit1");
      wr(3'd2, 16'h0002);
      chk_irq(1'b1, "R4 mask clear of bit1 keeps line");
      rd(3'd4, 16'h0001, "R4 mask clear bit1 only");
      // R6: collision on the same bit
      step(1'b1, 3'd1, 16'h0001, 1'b1, 1'b0);
      chk_irq(1'b1, "R6 event beats clear");
      rd(3'd0, 16'h0001, "R6 bit0 held");
      // R6 / R3: pulse top while clearing bottom
      step(1'b1, 3'd1, 16'h0001, 1'b0, 1'b1);
      chk_irq(1'b0, "R5 only unmasked bit pending");
      rd(3'd0, 16'h0002, "R6 top set bottom cleared");
      // R9: writes to read addresses ignored
      wr(3'd0, 16'hFFFF);
      wr(3'd4, 16'hFFFF);
      rd(3'd0, 16'h0002, "R9 status unchanged");
      rd(3'd4, 16'h0001, "R9 mask unchanged");
      // R7: upper bits read zero, unmapped address reads zero
      wr(3'd3, 16'hFFFF);
      chk_irq(1'b1, "R5 all enabled");
      rd(3'd4, 16'h0003, "R7 mask upper bits zero");
      rd(3'd5, 16'h0000, "R7 unmapped address");
      // R8: all-ones clears
      wr(3'd1, 16'hFFFF);
      chk_irq(1'b0, "R8 status cleared");
      wr(3'd2, 16'hFFFF);
      rd(3'd0, 16'h0000, "R8 status all clear");
      rd(3'd4, 16'h0000, "R8 mask all clear");
      repeat (2) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R7 reads outstanding: got %0d expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule